// File: doc/BRIEF.md
# Anti-Tearing Write Sequencer

This block sits in front of a nonvolatile byte memory and performs host writes so that a write cut short by a supply failure can be finished later. When the host asks for a protected write, the data first goes into a reserved record together with the destination address and the byte count. A marker flag in that record is set as the last step of this first phase. The record is then copied byte by byte to the destination, and the marker is cleared only after the last byte lands. After any power-up, the sequencer reads the marker. If the marker is still set, the sequencer replays the copy before it takes any host request.

Protection is chosen per request. An unprotected request writes straight to the destination, so it uses fewer memory cycles, and a page may be longer. A simple memory model with a programmable per-byte write latency stands in for the nonvolatile array. A power-fail input aborts the memory operation in progress and returns the controller to its power-up state. The memory contents, including the record, are kept. The host polls `busy` in the way it would poll for a bus acknowledge: while `busy` is high, requests are not taken.

Top module: `tearsafe_writer`

## Requirements
- R1: After reset every destination byte reads 0xFF, `err` is 0, and `busy` falls within a few cycles because no record is pending.
- R2: A request with `req_prot`=0 and a length of 1 to PLAIN_MAX writes byte i of `req_data` (bits 8*i+7..8*i) to address `req_addr`+i. It uses no record, so a power failure in the middle leaves the unwritten bytes at their old values after restart.
- R3: A request with `req_prot`=1 and a length of 1 to AT_MAX writes the same bytes through the record. Bytes outside the written range keep their values.
- R4: A request is rejected if its length is 0, or if it is longer than AT_MAX with `req_prot`=1, or longer than PLAIN_MAX with `req_prot`=0. A rejected request sets `err` in the cycle after it is presented, leaves `busy` low and changes no memory.
- R5: `busy` is high from the cycle after a request is accepted until the write completes. A request presented while `busy` is high is ignored.
- R6: If power fails after the copy phase of a protected write has begun, `busy` stays high after restart until the remaining bytes are written to their destination. All requested bytes then hold the new data.
- R7: If power fails before the record marker is set, the destination is left unchanged after restart, and no replay takes place.
- R8: `err` returns to 0 when the next request is accepted.
- R9: Addresses wrap modulo the memory size, so a write that runs past the top address continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset. Also blanks the memory model |
| pwr_fail | input | 1 | Supply failure. Aborts the memory operation and holds the controller at power-up |
| req_valid | input | 1 | Write request strobe, taken when `busy` is low |
| req_prot | input | 1 | 1 = protected write through the record, 0 = direct write |
| req_addr | input | $clog2(MEM_BYTES) | First destination address |
| req_len | input | $clog2(PLAIN_MAX+1) | Number of bytes |
| req_data | input | 8*PLAIN_MAX | Data, byte i in bits 8*i+7..8*i |
| busy | output | 1 | High while writing or recovering. No acknowledge is given while high |
| err | output | 1 | Last request was rejected |
| rd_addr | input | $clog2(MEM_BYTES) | Read address into the destination memory |
| rd_data | output | 8 | Destination byte at `rd_addr` (combinational) |

## Verification
The bench builds the block with a 32-byte memory, a write latency of 3 cycles per byte, an 8-byte limit for protected writes and a 16-byte limit for direct writes. The small memory makes the wrap-around path easy to reach with short requests. The short latency lets the bench watch a single destination byte land and then cut the power exactly between two copy steps, so both the replay and the no-replay outcomes can be observed. A 16-byte direct write on the 32-byte array also reaches the wrap, and protected requests of 9 and 16 bytes reach the length rejection.

// File: rtl/atw_pkg.sv
package atw_pkg;

    // Controller states
    typedef enum logic [2:0] {
        S_BOOT,    // power-up check of the record marker
        S_IDLE,
        S_DIRECT,  // unprotected byte writes
        S_BDATA,   // record data bytes
        S_BHDR,    // record address and count
        S_BMARK,   // set marker (last step of phase one)
        S_COPY,    // record -> destination
        S_CLEAR    // clear marker (last step of phase two)
    } seq_state_e;

    // Memory operation kinds
    typedef enum logic [1:0] {
        OP_TGT,    // destination byte
        OP_RDATA,  // record data byte
        OP_RHDR,   // record address + count
        OP_RMARK   // record marker <= data[0]
    } nvm_op_e;

    function automatic logic len_ok(input logic prot, input int unsigned len,
                                    input int unsigned at_max, input int unsigned plain_max);
        if (len == 0) return 1'b0;
        if (prot) return len <= at_max;
        return len <= plain_max;
    endfunction

endpackage

// File: rtl/atw_nvm.sv
module atw_nvm
    import atw_pkg::*;
#(
    parameter int MEM_BYTES = 64,
    parameter int AT_MAX    = 8,
    parameter int PLAIN_MAX = 16,
    parameter int WR_LAT    = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pwr_fail,
    input  logic                         go,
    input  nvm_op_e                      op,
    input  logic [$clog2(AT_MAX)-1:0]    op_idx,
    input  logic [$clog2(MEM_BYTES)-1:0] op_addr,
    input  logic [$clog2(PLAIN_MAX+1)-1:0] op_len,
    input  logic [7:0]                   op_data,
    output logic                         busy,
    output logic                         done,
    input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
    output logic [7:0]                   rd_data,
    output logic                         rec_valid,
    output logic [$clog2(MEM_BYTES)-1:0] rec_addr,
    output logic [$clog2(PLAIN_MAX+1)-1:0] rec_len,
    output logic [8*AT_MAX-1:0]          rec_data
);
    localparam int AW  = $clog2(MEM_BYTES);
    localparam int LW  = $clog2(PLAIN_MAX + 1);
    localparam int BIW = $clog2(AT_MAX);
    localparam int CW  = $clog2(WR_LAT + 1);

    logic [7:0]     mem [MEM_BYTES];
    logic [CW-1:0]  cnt_q;
    nvm_op_e        lat_op;
    logic [BIW-1:0] lat_idx;
    logic [AW-1:0]  lat_addr;
    logic [LW-1:0]  lat_len;
    logic [7:0]     lat_data;

    // An operation commits on the edge where its counter reaches one,
    // unless the supply fails on that very edge.
    assign done    = busy && (cnt_q == CW'(1)) && !pwr_fail;
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
            rec_valid <= 1'b0;
            rec_addr  <= '0;
            rec_len   <= '0;
            rec_data  <= '0;
            busy      <= 1'b0;
            cnt_q     <= '0;
            lat_op    <= OP_TGT;
            lat_idx   <= '0;
            lat_addr  <= '0;
            lat_len   <= '0;
            lat_data  <= '0;
        end else if (pwr_fail) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (go) begin
            busy     <= 1'b1;
            cnt_q    <= CW'(WR_LAT);
            lat_op   <= op;
            lat_idx  <= op_idx;
            lat_addr <= op_addr;
            lat_len  <= op_len;
            lat_data <= op_data;
        end else if (busy) begin
            if (cnt_q == CW'(1)) begin
                busy <= 1'b0;
                unique case (lat_op)
                    OP_TGT:   mem[lat_addr] <= lat_data;
                    OP_RDATA: rec_data[8*lat_idx +: 8] <= lat_data;
                    OP_RHDR: begin
                        rec_addr <= lat_addr;
                        rec_len  <= lat_len;
                    end
                    OP_RMARK: rec_valid <= lat_data[0];
                endcase
            end
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // R5: the controller never starts an operation on top of another one
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst || pwr_fail)
        go |-> !busy);

    // R6: a supply failure kills the operation in flight
    a_r6_abort_clears: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> !busy);

endmodule

// File: rtl/atw_seq.sv
module atw_seq
    import atw_pkg::*;
#(
    parameter int MEM_BYTES = 64,
    parameter int AT_MAX    = 8,
    parameter int PLAIN_MAX = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           pwr_fail,
    input  logic                           req_valid,
    input  logic                           req_prot,
    input  logic [$clog2(MEM_BYTES)-1:0]   req_addr,
    input  logic [$clog2(PLAIN_MAX+1)-1:0] req_len,
    input  logic [8*PLAIN_MAX-1:0]         req_data,
    output logic                           busy,
    output logic                           err,
    output logic                           go,
    output nvm_op_e                        op,
    output logic [$clog2(AT_MAX)-1:0]      op_idx,
    output logic [$clog2(MEM_BYTES)-1:0]   op_addr,
    output logic [$clog2(PLAIN_MAX+1)-1:0] op_len,
    output logic [7:0]                     op_data,
    input  logic                           nvm_busy,
    input  logic                           nvm_done,
    input  logic                           rec_valid,
    input  logic [$clog2(MEM_BYTES)-1:0]   rec_addr,
    input  logic [$clog2(PLAIN_MAX+1)-1:0] rec_len,
    input  logic [8*AT_MAX-1:0]            rec_data
);
    localparam int AW  = $clog2(MEM_BYTES);
    localparam int LW  = $clog2(PLAIN_MAX + 1);
    localparam int IW  = $clog2(PLAIN_MAX);
    localparam int BIW = $clog2(AT_MAX);

    seq_state_e             state;
    logic [IW-1:0]          idx;
    logic                   pend;
    logic [AW-1:0]          h_addr;
    logic [LW-1:0]          h_len;
    logic [8*PLAIN_MAX-1:0] h_data;
    logic                   need_op, accept, req_ok, last_h, last_r;

    assign busy    = (state != S_IDLE);
    assign req_ok  = len_ok(req_prot, int'(req_len), AT_MAX, PLAIN_MAX);
    assign accept  = (state == S_IDLE) && req_valid;
    assign need_op = (state != S_IDLE) && (state != S_BOOT);
    assign go      = need_op && !pend;
    assign last_h  = (LW'(idx) + LW'(1)) == h_len;
    assign last_r  = (LW'(idx) + LW'(1)) == rec_len;
    assign op_idx  = idx[BIW-1:0];

    always_comb begin
        op      = OP_TGT;
        op_addr = AW'(h_addr + AW'(idx));
        op_len  = h_len;
        op_data = h_data[8*idx +: 8];
        unique case (state)
            S_BDATA: op = OP_RDATA;
            S_BHDR: begin
                op      = OP_RHDR;
                op_addr = h_addr;
            end
            S_BMARK: begin
                op      = OP_RMARK;
                op_data = 8'h01;
            end
            S_COPY: begin
                op_addr = AW'(rec_addr + AW'(idx));
                op_data = rec_data[8*op_idx +: 8];
            end
            S_CLEAR: begin
                op      = OP_RMARK;
                op_data = 8'h00;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || pwr_fail) begin
            state  <= S_BOOT;
            idx    <= '0;
            pend   <= 1'b0;
            err    <= 1'b0;
            h_addr <= '0;
            h_len  <= '0;
            h_data <= '0;
        end else begin
            if (go) pend <= 1'b1;
            else if (nvm_done) pend <= 1'b0;

            unique case (state)
                S_BOOT: begin
                    idx   <= '0;
                    state <= rec_valid ? S_COPY : S_IDLE;
                end
                S_IDLE: if (accept) begin
                    err <= !req_ok;
                    if (req_ok) begin
                        h_addr <= req_addr;
                        h_len  <= req_len;
                        h_data <= req_data;
                        idx    <= '0;
                        state  <= req_prot ? S_BDATA : S_DIRECT;
                    end
                end
                default: if (nvm_done) begin
                    unique case (state)
                        S_DIRECT: if (last_h) state <= S_IDLE;
                                  else idx <= idx + IW'(1);
                        S_BDATA: if (last_h) begin
                                     idx   <= '0;
                                     state <= S_BHDR;
                                 end else idx <= idx + IW'(1);
                        S_BHDR:  state <= S_BMARK;
                        S_BMARK: begin
                            idx   <= '0;
                            state <= S_COPY;
                        end
                        S_COPY:  if (last_r) state <= S_CLEAR;
                                 else idx <= idx + IW'(1);
                        S_CLEAR: state <= S_IDLE;
                        default: ;
                    endcase
                end
            endcase
        end
    end

    // R6: the controller is never idle with a pending record
    a_r6_idle_no_record: assert property (@(posedge clk) disable iff (rst || pwr_fail)
        (state == S_IDLE) |-> !rec_valid);

    // R4: a rejected request leaves the sequencer idle with the error raised
    a_r4_reject_idle: assert property (@(posedge clk) disable iff (rst || pwr_fail)
        (state == S_IDLE && req_valid && !req_ok) |=> (state == S_IDLE && err));

    // R3: the marker rises only as the final step of phase one
    a_r3_mark_last: assert property (@(posedge clk) disable iff (rst)
        $rose(rec_valid) |-> $past(state == S_BMARK));

    // R7: the marker falls only as the final step of phase two
    a_r7_clear_last: assert property (@(posedge clk) disable iff (rst)
        $fell(rec_valid) |-> $past(state == S_CLEAR));

    // R5: the memory model is only seen busy while the sequencer is working
    a_r5_busy_cover: assert property (@(posedge clk) disable iff (rst || pwr_fail)
        nvm_busy |-> busy);

endmodule

// File: rtl/tearsafe_writer.sv
module tearsafe_writer
    import atw_pkg::*;
#(
    parameter int MEM_BYTES = 64,
    parameter int AT_MAX    = 8,
    parameter int PLAIN_MAX = 16,
    parameter int WR_LAT    = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           pwr_fail,
    input  logic                           req_valid,
    input  logic                           req_prot,
    input  logic [$clog2(MEM_BYTES)-1:0]   req_addr,
    input  logic [$clog2(PLAIN_MAX+1)-1:0] req_len,
    input  logic [8*PLAIN_MAX-1:0]         req_data,
    output logic                           busy,
    output logic                           err,
    input  logic [$clog2(MEM_BYTES)-1:0]   rd_addr,
    output logic [7:0]                     rd_data
);
    localparam int AW  = $clog2(MEM_BYTES);
    localparam int LW  = $clog2(PLAIN_MAX + 1);
    localparam int BIW = $clog2(AT_MAX);

    logic           go, nvm_busy, nvm_done, rec_valid;
    nvm_op_e        op;
    logic [BIW-1:0] op_idx;
    logic [AW-1:0]  op_addr, rec_addr;
    logic [LW-1:0]  op_len, rec_len;
    logic [7:0]     op_data;
    logic [8*AT_MAX-1:0] rec_data;

    atw_seq #(.MEM_BYTES(MEM_BYTES), .AT_MAX(AT_MAX), .PLAIN_MAX(PLAIN_MAX)) u_seq (
        .clk, .rst, .pwr_fail, .req_valid, .req_prot, .req_addr, .req_len, .req_data,
        .busy, .err, .go, .op, .op_idx, .op_addr, .op_len, .op_data,
        .nvm_busy, .nvm_done, .rec_valid, .rec_addr, .rec_len, .rec_data
    );

    atw_nvm #(.MEM_BYTES(MEM_BYTES), .AT_MAX(AT_MAX), .PLAIN_MAX(PLAIN_MAX),
              .WR_LAT(WR_LAT)) u_nvm (
        .clk, .rst, .pwr_fail, .go, .op, .op_idx, .op_addr, .op_len, .op_data,
        .busy(nvm_busy), .done(nvm_done), .rd_addr, .rd_data,
        .rec_valid, .rec_addr, .rec_len, .rec_data
    );

    // R4: a request is never rejected while one is being worked on
    a_r4_err_only_idle: assert property (@(posedge clk) disable iff (rst || pwr_fail)
        $rose(err) |-> $past(req_valid && !busy));

endmodule

// File: tb/sim_tearsafe_writer.sv
`timescale 1ns/1ps
module sim_tearsafe_writer;
    localparam int MB = 32, ATM = 8, PM = 16, LAT = 3;

    typedef struct packed {
        logic       prot;
        logic [4:0] addr;
        logic [4:0] len;
        logic [7:0] seed;
        logic       exp_err;
        logic [7:0] req;
    } vec_t;

    // R2 direct, R3 protected, R4 rejection, R8 err cleared, R9 wrap
    localparam vec_t VECS [8] = '{
        '{1'b1, 5'd2,  5'd8,  8'd10,  1'b0, 8'd3},   // R3 full 8-byte protected
        '{1'b0, 5'd20, 5'd16, 8'd40,  1'b0, 8'd9},   // R9 direct 16 bytes wraps
        '{1'b1, 5'd5,  5'd9,  8'd60,  1'b1, 8'd4},   // R4 protected too long
        '{1'b1, 5'd9,  5'd1,  8'd70,  1'b0, 8'd8},   // R8 single byte clears err
        '{1'b0, 5'd0,  5'd0,  8'd80,  1'b1, 8'd4},   // R4 zero length
        '{1'b1, 5'd30, 5'd4,  8'd90,  1'b0, 8'd9},   // R9 protected wraps
        '{1'b0, 5'd12, 5'd3,  8'd100, 1'b0, 8'd2},   // R2 direct short
        '{1'b1, 5'd0,  5'd16, 8'd110, 1'b1, 8'd4}    // R4 protected 16 bytes
    };

    logic clk = 0, rst = 1, pwr_fail = 0, req_valid = 0, req_prot = 0;
    logic [4:0] req_addr = '0, req_len = '0, rd_addr = '0;
    logic [8*PM-1:0] req_data = '0;
    logic busy, err;
    logic [7:0] rd_data;
    logic [7:0] sh [MB];
    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tearsafe_writer #(.MEM_BYTES(MB), .AT_MAX(ATM), .PLAIN_MAX(PM), .WR_LAT(LAT)) u0 (
        .clk, .rst, .pwr_fail, .req_valid, .req_prot, .req_addr, .req_len, .req_data,
        .busy, .err, .rd_addr, .rd_data
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic prot, input logic [4:0] addr, input logic [4:0] len,
                        input logic [7:0] seed);
        @(negedge clk);
        req_valid = 1; req_prot = prot; req_addr = addr; req_len = len;
        for (int i = 0; i < PM; i++) req_data[8*i +: 8] = seed + 8'(i);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic shadow_write(input logic [4:0] addr, input int len, input logic [7:0] seed);
        for (int i = 0; i < len; i++) sh[(int'(addr) + i) % MB] = seed + 8'(i);
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
        if (busy) chk(0, req, 1, 0);
    endtask

    task automatic wait_byte(input logic [4:0] addr, input logic [7:0] val, input string req);
        int n = 0;
        rd_addr = addr; #1;
        while (rd_data != val && n < 2000) begin @(negedge clk); n++; end
        if (rd_data != val) chk(0, req, int'(rd_data), int'(val));
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0, first_a = 0, first_v = 0, first_e = 0;
        for (int i = 0; i < MB; i++) begin
            rd_addr = 5'(i); #1;
            if (rd_data !== sh[i]) begin
                if (bad == 0) begin first_a = i; first_v = int'(rd_data); first_e = int'(sh[i]); end
                bad++;
            end
        end
        if (bad != 0) $display("  mismatch at address %0d", first_a);
        chk(bad == 0, req, first_v, first_e);
    endtask

    task automatic power_cut(input int n);
        @(negedge clk); pwr_fail = 1;
        repeat (n) @(negedge clk);
        pwr_fail = 0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "R5 watchdog", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MB; i++) sh[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 0;
        wait_idle("R1 busy after reset");
        chk(busy == 0, "R1 busy after reset", int'(busy), 0);
        chk(err == 0, "R1 err after reset", int'(err), 0);
        cmp_mem("R1 blank memory");

        // Vector table walk
        foreach (VECS[k]) begin
            send(VECS[k].prot, VECS[k].addr, VECS[k].len, VECS[k].seed);
            if (VECS[k].exp_err)
                chk(busy == 0, $sformatf("R%0d vec %0d reject no busy", VECS[k].req, k), int'(busy), 0);
            wait_idle($sformatf("R%0d vec %0d", VECS[k].req, k));
            chk(err == VECS[k].exp_err, $sformatf("R%0d vec %0d err", VECS[k].req, k),
                int'(err), int'(VECS[k].exp_err));
            if (!VECS[k].exp_err) shadow_write(VECS[k].addr, int'(VECS[k].len), VECS[k].seed);
            cmp_mem($sformatf("R%0d vec %0d memory", VECS[k].req, k));
        end

        // R5: busy after accept, second request ignored
        send(1'b1, 5'd16, 5'd2, 8'd120);
        chk(busy == 1, "R5 busy after accept", int'(busy), 1);
        @(negedge clk);
        send(1'b0, 5'd24, 5'd1, 8'd200);
        wait_idle("R5 completion");
        shadow_write(5'd16, 2, 8'd120);
        cmp_mem("R5 request during busy ignored");

        // R6: cut after the first copy byte landed, replay at restart
        send(1'b1, 5'd8, 5'd6, 8'd130);
        wait_byte(5'd8, 8'd130, "R6 first copy byte");
        @(negedge clk); pwr_fail = 1;
        rd_addr = 5'd13; #1;
        chk(rd_data == sh[13], "R6 tail not yet written at cut", int'(rd_data), int'(sh[13]));
        repeat (4) @(negedge clk);
        pwr_fail = 0;
        @(negedge clk);
        chk(busy == 1, "R6 busy during recovery", int'(busy), 1);
        wait_idle("R6 recovery");
        shadow_write(5'd8, 6, 8'd130);
        cmp_mem("R6 recovered bytes");

        // R7: cut before marker set, no change
        send(1'b1, 5'd24, 5'd3, 8'd150);
        @(negedge clk);
        power_cut(4);
        wait_idle("R7 restart");
        cmp_mem("R7 destination unchanged");

        // R2: direct write torn, no replay
        send(1'b0, 5'd0, 5'd4, 8'd170);
        wait_byte(5'd0, 8'd170, "R2 first direct byte");
        power_cut(4);
        wait_idle("R2 restart");
        sh[0] = 8'd170;
        cmp_mem("R2 torn direct write not replayed");

        // R8: error then accepted request clears it
        send(1'b1, 5'd1, 5'd12, 8'd1);
        chk(err == 1, "R8 err raised", int'(err), 1);
        send(1'b0, 5'd1, 5'd1, 8'd5);
        wait_idle("R8 completion");
        chk(err == 0, "R8 err cleared", int'(err), 0);
        sh[1] = 8'd5;
        cmp_mem("R8 memory");

        finished = 1;
        summary();
        $finish;
    end
endmodule